// File: doc/BRIEF.md
# Line-Shared Context Broadcast Unit

This unit feeds configuration words to a square array of word-level processing cells that runs in SIMD fashion. It keeps one bank of context storage per array line. On an issue command it reads one address from every bank at once and sends each bank's word to its own line, so all cells on a line share one configuration while neighbouring lines may run different ones. A mode bit on the command says whether the lines are the array's rows or its columns. That bit is registered together with the contexts, so the array never sees a context and a mode from different commands.

A host write port fills the banks one word at a time. This port works independently of the command port, so new contexts can be loaded while the array executes. A per-line enable mask on the command lets some lines keep their current context while others are reloaded. A one-cycle load pulse per line tells the array which lines took a new word.

Top module: `ctx_bcast`

## Requirements
- R1: While reset is high and in the cycle after it is released, every context output is zero, `mode_o` is 0 (row mode) and `load_o` is all zero.
- R2: A word written with `wr_bank`=b and `wr_addr`=a appears on context lane b (bits b*32+31 down to b*32 of `ctx_o`) after a later issue with `cmd_addr`=a and bit b of `cmd_en` set.
- R3: An issue sampled at clock edge t changes the enabled lanes at edge t and nowhere else. In the cycle after t, `load_o` equals the `cmd_en` that was issued. With no issue, `load_o` is zero in the following cycle.
- R4: A lane whose `cmd_en` bit is clear during an issue keeps its previous context value.
- R5: A host write changes only the one bank and address it selects. The stored words of all other banks, and of all other addresses, stay the same.
- R6: `mode_o` takes the value of `cmd_mode` (0 = lanes are rows, 1 = lanes are columns) at each issue, and this happens even when the enable mask is all zero. Between issues it holds its value.
- R7: When a write and an issue hit the same bank and address in one cycle, the lane receives the value stored before the write. The next issue of that address delivers the new value.
- R8: A write to a different address in the same cycle as an issue has full effect. The issue delivers the stored words, and a later issue of the written address returns the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_bank | input | $clog2(LINES) | Bank (line) selected for the write |
| wr_addr | input | $clog2(DEPTH) | Word address within the bank |
| wr_data | input | CTX_W | Context word to store |
| cmd_issue | input | 1 | Broadcast strobe |
| cmd_mode | input | 1 | 0 = lanes drive rows, 1 = lanes drive columns |
| cmd_addr | input | $clog2(DEPTH) | Address read from every bank |
| cmd_en | input | LINES | Per-lane reload enable |
| ctx_o | output | LINES*CTX_W | Context words, lane i at bits i*CTX_W upward |
| load_o | output | LINES | One-cycle pulse for each lane that took a new word |
| mode_o | output | 1 | Registered row/column mode |

## Verification
A corrupted bank word shows up as a wrong lane value in the cycle right after the first issue that reads that address. A bad bank decode shows up on a lane other than the one written. The mode and enable registers are observable on the cycle after every issue. The lane hold registers are observable on every cycle that follows an issue with a partial mask. For this reason the bench sweeps every address on every lane and every one of the 256 masks, and checks each lane after each issue.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    localparam int unsigned DEF_LINES = 8;
    localparam int unsigned DEF_CTX_W = 32;
    localparam int unsigned DEF_DEPTH = 1024;

    typedef enum logic {
        LANE_ROW = 1'b0,
        LANE_COL = 1'b1
    } lane_mode_e;

    function automatic logic bank_hit(input logic en, input int unsigned sel, input int unsigned idx);
        return en && (sel == idx);
    endfunction

endpackage

// File: rtl/ctx_wr_decode.sv
module ctx_wr_decode
    import ctx_pkg::*;
#(
    parameter int unsigned LINES = DEF_LINES,
    localparam int unsigned LW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LW-1:0]    wr_bank,
    output logic [LINES-1:0] bank_we
);

    for (genvar i = 0; i < LINES; i++) begin : g_dec
        assign bank_we[i] = bank_hit(wr_en, int'(wr_bank), i);
    end

    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_we)); // R5

    AST_WR_FOLLOWS_EN: assert property (@(posedge clk) disable iff (rst)
        (bank_we != '0) == wr_en); // R5

endmodule

// File: rtl/ctx_bank.sv
module ctx_bank
    import ctx_pkg::*;
#(
    parameter int unsigned CTX_W = DEF_CTX_W,
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [CTX_W-1:0] wdata,
    input  logic             rd_en,
    input  logic [AW-1:0]    raddr,
    output logic [CTX_W-1:0] ctx_q
);

    logic [CTX_W-1:0] mem [DEPTH];

    // storage array, no reset
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // lane context register doubles as the read register: one-cycle load,
    // and a same-cycle write is seen only on the following read
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else if (rd_en) begin
            ctx_q <= mem[raddr];
        end
    end

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(ctx_q)); // R4

endmodule

// File: rtl/ctx_cmd_reg.sv
module ctx_cmd_reg
    import ctx_pkg::*;
#(
    parameter int unsigned LINES = DEF_LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  lane_mode_e       mode_in,
    input  logic [LINES-1:0] en_in,
    output lane_mode_e       mode_q,
    output logic [LINES-1:0] load_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= LANE_ROW;
            load_q <= '0;
        end else begin
            load_q <= issue ? en_in : '0;
            if (issue) begin
                mode_q <= mode_in;
            end
        end
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(mode_q)); // R6

    AST_LOAD_TRACK: assert property (@(posedge clk) disable iff (rst)
        issue |=> load_q == $past(en_in)); // R3

    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !issue |=> load_q == '0); // R3

endmodule

// File: rtl/ctx_bcast.sv
module ctx_bcast
    import ctx_pkg::*;
#(
    parameter int unsigned LINES = DEF_LINES,
    parameter int unsigned CTX_W = DEF_CTX_W,
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned LW = $clog2(LINES),
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [LW-1:0]          wr_bank,
    input  logic [AW-1:0]          wr_addr,
    input  logic [CTX_W-1:0]       wr_data,
    input  logic                   cmd_issue,
    input  logic                   cmd_mode,
    input  logic [AW-1:0]          cmd_addr,
    input  logic [LINES-1:0]       cmd_en,
    output logic [LINES*CTX_W-1:0] ctx_o,
    output logic [LINES-1:0]       load_o,
    output logic                   mode_o
);

    logic [LINES-1:0] bank_we;
    logic [CTX_W-1:0] lane_ctx [LINES];
    lane_mode_e       mode_q;

    ctx_wr_decode #(.LINES(LINES)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .bank_we (bank_we)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_lane
        ctx_bank #(.CTX_W(CTX_W), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (bank_we[i]),
            .waddr (wr_addr),
            .wdata (wr_data),
            .rd_en (cmd_issue && cmd_en[i]),
            .raddr (cmd_addr),
            .ctx_q (lane_ctx[i])
        );
        assign ctx_o[i*CTX_W +: CTX_W] = lane_ctx[i];
    end

    ctx_cmd_reg #(.LINES(LINES)) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .issue   (cmd_issue),
        .mode_in (lane_mode_e'(cmd_mode)),
        .en_in   (cmd_en),
        .mode_q  (mode_q),
        .load_q  (load_o)
    );

    assign mode_o = mode_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (ctx_o == '0 && load_o == '0 && !mode_o)); // R1

    AST_LANE_CHANGE_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
        $changed(ctx_o) |-> load_o != '0); // R3

endmodule

// File: tb/test_ctx_bcast.sv
module test_ctx_bcast;

    localparam int LINES = 8;
    localparam int CW    = 32;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                wr_en = 1'b0;
    logic [2:0]          wr_bank = '0;
    logic [AW-1:0]       wr_addr = '0;
    logic [CW-1:0]       wr_data = '0;
    logic                cmd_issue = 1'b0;
    logic                cmd_mode = 1'b0;
    logic [AW-1:0]       cmd_addr = '0;
    logic [LINES-1:0]    cmd_en = '0;
    logic [LINES*CW-1:0] ctx_o;
    logic [LINES-1:0]    load_o;
    logic                mode_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [CW-1:0] exp_lane [LINES];

    always #5 clk = ~clk;

    ctx_bcast #(.LINES(LINES), .CTX_W(CW), .DEPTH(DEPTH)) i_ctx_bcast (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmd_issue(cmd_issue), .cmd_mode(cmd_mode),
        .cmd_addr(cmd_addr), .cmd_en(cmd_en), .ctx_o(ctx_o), .load_o(load_o),
        .mode_o(mode_o)
    );

    function automatic logic [CW-1:0] pat(input int b, input int a);
        return CW'(b * 32'h0100_0000 + a * 32'h0001_0000 + (b ^ a) * 32'h11 + 32'h5A);
    endfunction

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_lanes(input string req);
        for (int i = 0; i < LINES; i++) check(req, ctx_o[i*CW +: CW], exp_lane[i]);
    endtask

    // drive at negedge, let one posedge pass, return at next negedge
    task automatic step(input logic we, input int bank, input int waddr, input logic [CW-1:0] wd,
                        input logic iss, input logic md, input int raddr, input logic [LINES-1:0] en);
        wr_en = we; wr_bank = 3'(bank); wr_addr = AW'(waddr); wr_data = wd;
        cmd_issue = iss; cmd_mode = md; cmd_addr = AW'(raddr); cmd_en = en;
        @(negedge clk);
        wr_en = 1'b0; cmd_issue = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 ctx", ctx_o[CW-1:0], '0);
        check("R1 mode", CW'(mode_o), '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 load", CW'(load_o), '0);
        for (int i = 0; i < LINES; i++) exp_lane[i] = '0;
        check_lanes("R1 lanes");

        // fill all banks
        for (int b = 0; b < LINES; b++)
            for (int a = 0; a < DEPTH; a++)
                step(1, b, a, pat(b, a), 0, 0, 0, '0);
        check("R5 no load during writes", CW'(load_o), '0);

        // R2/R5: every address, all lanes, alternating mode
        for (int a = 0; a < DEPTH; a++) begin
            step(0, 0, 0, '0, 1, a[0], a, 8'hFF);
            for (int i = 0; i < LINES; i++) exp_lane[i] = pat(i, a);
            check_lanes("R2 sweep");
            check("R3 load mask", CW'(load_o), 32'hFF);
            check("R6 mode", CW'(mode_o), CW'(a[0]));
        end
        step(0, 0, 0, '0, 0, 0, 0, '0);
        check("R3 load idle", CW'(load_o), '0);
        check("R6 mode held", CW'(mode_o), 32'd1);

        // R4: all masks
        for (int m = 0; m < 256; m++) begin
            int a;
            a = (m * 7 + 3) % DEPTH;
            step(0, 0, 0, '0, 1, m[1], a, 8'(m));
            for (int i = 0; i < LINES; i++) if (m[i]) exp_lane[i] = pat(i, a);
            check_lanes("R4 mask sweep");
            check("R3 load per mask", CW'(load_o), CW'(m));
        end

        // R6: zero mask still updates mode
        step(0, 0, 0, '0, 1, 1, 9, 8'h00);
        check("R6 mode zero mask", CW'(mode_o), 32'd1);
        check_lanes("R4 zero mask");
        step(0, 0, 0, '0, 1, 0, 9, 8'h00);
        check("R6 mode back to row", CW'(mode_o), 32'd0);

        // R7: same bank/address collision returns old word
        step(1, 3, 5, 32'hDEAD_BEEF, 1, 0, 5, 8'hFF);
        for (int i = 0; i < LINES; i++) exp_lane[i] = pat(i, 5);
        check_lanes("R7 old value");
        step(0, 0, 0, '0, 1, 0, 5, 8'h08);
        exp_lane[3] = 32'hDEAD_BEEF;
        check_lanes("R7 new value next read");

        // R8: concurrent write elsewhere
        step(1, 2, 7, 32'h1234_5678, 1, 1, 4, 8'hFF);
        for (int i = 0; i < LINES; i++) exp_lane[i] = pat(i, 4);
        check_lanes("R8 issue during write");
        step(0, 0, 0, '0, 1, 1, 7, 8'hFF);
        for (int i = 0; i < LINES; i++) exp_lane[i] = pat(i, 7);
        exp_lane[2] = 32'h1234_5678;
        check_lanes("R8 written word");
        check("R5 neighbour bank", ctx_o[1*CW +: CW], pat(1, 7));

        finish_run();
    end

endmodule